// File: doc/BRIEF.md
# Pulse Tone Channel with Frequency Sweep

This block generates one square-wave tone as a 4-bit amplitude sample. A host sets it up through five byte-wide registers: sweep setup, duty and length, volume envelope, the low frequency byte, and the high frequency bits with a trigger bit. Four single-cycle strobes come from outside the block. The period tick moves the waveform. The length, envelope and sweep ticks pace the slower controls.

Frequency is an 11-bit code F. The waveform moves one of eight positions every 2048 - F period ticks. A length counter can silence the tone after a programmed time. The envelope ramps the volume up or down one level per step, and stops at 0 and at 15. A sweep unit adds or subtracts F shifted right by a programmed count to retune the tone. When an addition goes past the 11-bit range, the channel switches off.

Top module: `pulse_sweep_chan`

## Requirements
- R1: Wave position p (0..7) is high when p < H. H is 1, 2, 4 or 6 for duty code 0, 1, 2 or 3 in bits 7-6 of the duty/length register (address 1). The sample is the current volume while the position is high and the channel is on, and 0 otherwise.
- R2: F is formed from address 3 (bits 7-0) and bits 2-0 of address 4 (bits 10-8). Each expiry of the period counter advances the position by one, and the expiry comes every 2048 - F period ticks. A reload uses the frequency value current at that expiry.
- R3: A write to address 4 with bit 7 set turns the channel on in the next cycle and resets the position to 0. The same write loads the period counter, the volume, the length counter and the sweep interval counter. A write with bit 7 clear triggers nothing.
- R4: If bit 6 of address 4 is 1, the channel switches off on the (64 - L)th length tick after the trigger, where L is bits 5-0 of address 1. If bit 6 is 0, length ticks never switch the channel off.
- R5: Address 2 holds the starting volume (bits 7-4), the direction (bit 3: 1 up, 0 down) and the step period P (bits 2-0). The volume moves by 1 every P envelope ticks and stops at 0 and at 15. P = 0 holds the volume.
- R6: Address 0 holds the interval T (bits 6-4), the direction (bit 3: 0 add, 1 subtract) and the shift S (bits 2-0). Every T sweep ticks, F becomes F ± (F >> S). T = 0 turns the sweep off, and S = 0 leaves F unchanged.
- R7: A sweep addition whose result exceeds 2047 switches the channel off and leaves F unchanged.
- R8: Readback returns the following. Address 0 gives bits 6-0 as written, with bit 7 at 0. Address 1 gives only the duty bits. Address 2 gives the full byte. Address 3 gives 0. Address 4 gives only bit 6. All bits that do not read back return 0.
- R9: After reset the channel is off, the sample is 0 and every register reads 0.
- R10: While the channel is off the sample is 0, whatever the period ticks do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address (0..4) |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | 8 | Readback data (combinational) |
| period_tick_i | input | 1 | Period counter step enable |
| len_tick_i | input | 1 | Length counter step enable |
| env_tick_i | input | 1 | Envelope step enable |
| sweep_tick_i | input | 1 | Sweep step enable |
| sample_o | output | 4 | Amplitude sample |
| active_o | output | 1 | Channel on |

## Verification
The bench steps every duty code through two full waveform cycles. It then measures the number of period ticks per step against 2048 - F for several frequencies. A wrong duty table or an off-by-one reload shows up as a shifted edge or a wrong tick count. The sweep cases check the following:
- Retuning applies at the next expiry and not to the running count. A design that reloaded at once would give a wrong first-step count.
- An overflowing addition switches the channel off, and only after T ticks.
- S = 0 and T = 0 change nothing. A design that summed F + F there would cut the tone off.

The envelope is driven into both saturation points with P = 1 and P = 2. The length counter is checked at L = 60 and at the full count of 64 ticks, and a channel that is not length-limited must stay on through many length ticks.

// File: rtl/pulse_pkg.sv
package pulse_pkg;
  localparam logic [2:0] A_SWEEP = 3'd0;
  localparam logic [2:0] A_LEN   = 3'd1;
  localparam logic [2:0] A_ENV   = 3'd2;
  localparam logic [2:0] A_FLO   = 3'd3;
  localparam logic [2:0] A_FHI   = 3'd4;

  // number of high positions out of eight for each duty code
  function automatic logic [3:0] duty_high(input logic [1:0] code);
    case (code)
      2'd0:    return 4'd1;
      2'd1:    return 4'd2;
      2'd2:    return 4'd4;
      default: return 4'd6;
    endcase
  endfunction
endpackage

// File: rtl/pulse_wave.sv
module pulse_wave
  import pulse_pkg::*;
#(
  parameter int FREQ_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trig_i,
  input  logic              tick_i,
  input  logic [FREQ_W-1:0] trig_freq_i,
  input  logic [FREQ_W-1:0] freq_i,
  input  logic [1:0]        duty_i,
  output logic              high_o
);
  localparam int CNT_W = FREQ_W + 1;
  localparam logic [CNT_W-1:0] SPAN = {1'b1, {FREQ_W{1'b0}}};

  logic [CNT_W-1:0] cnt_q;
  logic [2:0]       pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= SPAN;
      pos_q <= '0;
    end else if (trig_i) begin
      cnt_q <= SPAN - {1'b0, trig_freq_i};
      pos_q <= '0;
    end else if (tick_i) begin
      if (cnt_q <= CNT_W'(1)) begin
        cnt_q <= SPAN - {1'b0, freq_i};
        pos_q <= pos_q + 3'd1;
      end else begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  assign high_o = {1'b0, pos_q} < duty_high(duty_i);
endmodule

// File: rtl/pulse_len.sv
module pulse_len #(
  parameter int LEN_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  logic             tick_i,
  input  logic             limit_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             expire_o
);
  localparam int CNT_W = LEN_W + 1;
  localparam logic [CNT_W-1:0] SPAN = {1'b1, {LEN_W{1'b0}}};

  logic [CNT_W-1:0] cnt_q;
  logic             step;

  assign step     = tick_i && limit_i && (cnt_q != '0);
  assign expire_o = step && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (trig_i)   cnt_q <= SPAN - {1'b0, len_i};
    else if (step)     cnt_q <= cnt_q - CNT_W'(1);
  end
endmodule

// File: rtl/pulse_env.sv
module pulse_env #(
  parameter int VOL_W = 4,
  parameter int PER_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  logic             tick_i,
  input  logic [VOL_W-1:0] init_i,
  input  logic             up_i,
  input  logic [PER_W-1:0] per_i,
  output logic [VOL_W-1:0] vol_o
);
  localparam logic [VOL_W-1:0] VMAX = '1;

  logic [PER_W-1:0] cnt_q;
  logic [VOL_W-1:0] vol_q;
  logic             fire;

  assign fire  = tick_i && (per_i != '0) && (cnt_q <= PER_W'(1));
  assign vol_o = vol_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      vol_q <= '0;
    end else if (trig_i) begin
      cnt_q <= per_i;
      vol_q <= init_i;
    end else if (tick_i && per_i != '0) begin
      if (fire) begin
        cnt_q <= per_i;
        if (up_i && vol_q != VMAX)      vol_q <= vol_q + VOL_W'(1);
        else if (!up_i && vol_q != '0)  vol_q <= vol_q - VOL_W'(1);
      end else begin
        cnt_q <= cnt_q - PER_W'(1);
      end
    end
  end
endmodule

// File: rtl/pulse_sweep.sv
module pulse_sweep #(
  parameter int FREQ_W = 11,
  parameter int INT_W  = 3,
  parameter int SH_W   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trig_i,
  input  logic              tick_i,
  input  logic [INT_W-1:0]  interval_i,
  input  logic              dec_i,
  input  logic [SH_W-1:0]   shift_i,
  input  logic [FREQ_W-1:0] freq_i,
  output logic              upd_o,
  output logic              ovf_o,
  output logic [FREQ_W-1:0] new_freq_o
);
  logic [INT_W-1:0] cnt_q;
  logic             fire, act;
  logic [FREQ_W:0]  delta, sum;

  assign fire  = tick_i && (interval_i != '0) && (cnt_q <= INT_W'(1));
  assign act   = fire && (shift_i != '0);
  assign delta = {1'b0, freq_i >> shift_i};
  assign sum   = dec_i ? ({1'b0, freq_i} - delta) : ({1'b0, freq_i} + delta);

  assign ovf_o      = act && !dec_i && sum[FREQ_W];
  assign upd_o      = act && !ovf_o;
  assign new_freq_o = sum[FREQ_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            cnt_q <= '0;
    else if (trig_i)                        cnt_q <= interval_i;
    else if (tick_i && interval_i != '0)    cnt_q <= fire ? interval_i : cnt_q - INT_W'(1);
  end
endmodule

// File: rtl/pulse_sweep_chan.sv
module pulse_sweep_chan
  import pulse_pkg::*;
#(
  parameter int FREQ_W = 11,
  parameter int LEN_W  = 6,
  parameter int VOL_W  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [2:0]       wr_addr_i,
  input  logic [7:0]       wr_data_i,
  input  logic [2:0]       rd_addr_i,
  output logic [7:0]       rd_data_o,
  input  logic             period_tick_i,
  input  logic             len_tick_i,
  input  logic             env_tick_i,
  input  logic             sweep_tick_i,
  output logic [VOL_W-1:0] sample_o,
  output logic             active_o
);
  localparam int HI_W = FREQ_W - 8;

  logic [6:0]        sweep_q;
  logic [1:0]        duty_q;
  logic [LEN_W-1:0]  len_q;
  logic [7:0]        env_q;
  logic [FREQ_W-1:0] freq_q;
  logic              limit_q;
  logic              active_q;

  logic              trig, wr_flo, wr_fhi;
  logic [FREQ_W-1:0] trig_freq;
  logic              wave_high, len_exp, sweep_upd, sweep_ovf;
  logic [FREQ_W-1:0] sweep_freq;
  logic [VOL_W-1:0]  vol;

  assign wr_flo    = wr_en_i && wr_addr_i == A_FLO;
  assign wr_fhi    = wr_en_i && wr_addr_i == A_FHI;
  assign trig      = wr_fhi && wr_data_i[7];
  assign trig_freq = {wr_data_i[HI_W-1:0], freq_q[7:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sweep_q  <= '0;
      duty_q   <= '0;
      len_q    <= '0;
      env_q    <= '0;
      freq_q   <= '0;
      limit_q  <= 1'b0;
      active_q <= 1'b0;
    end else begin
      if (wr_en_i && wr_addr_i == A_SWEEP) sweep_q <= wr_data_i[6:0];
      if (wr_en_i && wr_addr_i == A_LEN) begin
        duty_q <= wr_data_i[7:6];
        len_q  <= wr_data_i[LEN_W-1:0];
      end
      if (wr_en_i && wr_addr_i == A_ENV) env_q <= wr_data_i;
      // host writes take precedence over a sweep update in the same cycle
      if (wr_flo || wr_fhi) begin
        if (wr_flo) freq_q[7:0] <= wr_data_i;
        if (wr_fhi) begin
          freq_q[FREQ_W-1:8] <= wr_data_i[HI_W-1:0];
          limit_q            <= wr_data_i[6];
        end
      end else if (sweep_upd) begin
        freq_q <= sweep_freq;
      end
      if (trig)                       active_q <= 1'b1;
      else if (len_exp || sweep_ovf)  active_q <= 1'b0;
    end
  end

  pulse_wave #(.FREQ_W(FREQ_W)) u_wave (
    .clk_i, .rst_ni,
    .trig_i     (trig),
    .tick_i     (period_tick_i),
    .trig_freq_i(trig_freq),
    .freq_i     (freq_q),
    .duty_i     (duty_q),
    .high_o     (wave_high)
  );

  pulse_len #(.LEN_W(LEN_W)) u_len (
    .clk_i, .rst_ni,
    .trig_i  (trig),
    .tick_i  (len_tick_i && active_q),
    .limit_i (limit_q),
    .len_i   (len_q),
    .expire_o(len_exp)
  );

  pulse_env #(.VOL_W(VOL_W), .PER_W(3)) u_env (
    .clk_i, .rst_ni,
    .trig_i(trig),
    .tick_i(env_tick_i && active_q),
    .init_i(env_q[7:8-VOL_W]),
    .up_i  (env_q[3]),
    .per_i (env_q[2:0]),
    .vol_o (vol)
  );

  pulse_sweep #(.FREQ_W(FREQ_W), .INT_W(3), .SH_W(3)) u_sweep (
    .clk_i, .rst_ni,
    .trig_i    (trig),
    .tick_i    (sweep_tick_i && active_q),
    .interval_i(sweep_q[6:4]),
    .dec_i     (sweep_q[3]),
    .shift_i   (sweep_q[2:0]),
    .freq_i    (freq_q),
    .upd_o     (sweep_upd),
    .ovf_o     (sweep_ovf),
    .new_freq_o(sweep_freq)
  );

  assign active_o = active_q;
  assign sample_o = (active_q && wave_high) ? vol : '0;

  always_comb begin
    case (rd_addr_i)
      A_SWEEP: rd_data_o = {1'b0, sweep_q};
      A_LEN:   rd_data_o = {duty_q, 6'b0};
      A_ENV:   rd_data_o = env_q;
      A_FHI:   rd_data_o = {1'b0, limit_q, 6'b0};
      default: rd_data_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/pulse_sweep_chan_chk.sv
module pulse_sweep_chan_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       trig_i,
  input logic       active_i,
  input logic [3:0] sample_i,
  input logic [3:0] vol_i,
  input logic       env_up_i,
  input logic       ovf_i,
  input logic       limit_i,
  input logic [2:0] rd_addr_i,
  input logic [7:0] rd_data_i
);
  a_r10_idle_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |-> sample_i == 4'd0);

  a_r3_trigger_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |=> active_i);

  a_r5_sat_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vol_i == 4'd15 && env_up_i && !trig_i) |=> vol_i == 4'd15);

  a_r5_sat_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vol_i == 4'd0 && !env_up_i && !trig_i) |=> vol_i == 4'd0);

  a_r7_overflow_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_i && !trig_i) |=> !active_i);

  a_r4_continuous_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !limit_i && !ovf_i) |=> active_i);

  a_r8_duty_only_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_addr_i == 3'd1 |-> rd_data_i[5:0] == 6'd0);

  a_r8_flo_write_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_addr_i == 3'd3 |-> rd_data_i == 8'd0);
endmodule

bind pulse_sweep_chan pulse_sweep_chan_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .trig_i   (trig),
  .active_i (active_o),
  .sample_i (sample_o),
  .vol_i    (vol),
  .env_up_i (env_q[3]),
  .ovf_i    (sweep_ovf),
  .limit_i  (limit_q),
  .rd_addr_i(rd_addr_i),
  .rd_data_i(rd_data_o)
);

// File: tb/pulse_sweep_chan_bench.sv
module pulse_sweep_chan_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       t_per = 1'b0, t_len = 1'b0, t_env = 1'b0, t_swp = 1'b0;
  logic [3:0] sample;
  logic       active;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pulse_sweep_chan u_pulse_sweep_chan (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .period_tick_i(t_per), .len_tick_i(t_len),
    .env_tick_i(t_env), .sweep_tick_i(t_swp),
    .sample_o(sample), .active_o(active)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a[2:0]; wr_data = d[7:0];
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(int a, output int d);
    rd_addr = a[2:0]; #1; d = int'(rd_data);
  endtask

  // 0 period, 1 length, 2 envelope, 3 sweep
  task automatic tick(int k);
    @(negedge clk);
    case (k)
      0: t_per = 1'b1;
      1: t_len = 1'b1;
      2: t_env = 1'b1;
      default: t_swp = 1'b1;
    endcase
    @(negedge clk);
    t_per = 1'b0; t_len = 1'b0; t_env = 1'b0; t_swp = 1'b0;
  endtask

  task automatic trigger(int f, bit limit);
    wr(3, f & 255);
    wr(4, 128 | (limit ? 64 : 0) | (f >> 8));
  endtask

  task automatic count_until(bit want_zero, output int n);
    n = 0;
    while (((sample == 4'd0) != want_zero) && n < 20000) begin
      tick(0);
      n++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int d, n;
    int fl[5] = '{2047, 2046, 2044, 2040, 2030};
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 sample", int'(sample), 0);
    check("R9 active", int'(active), 0);
    for (int a = 0; a < 5; a++) begin rd(a, d); check("R9 readback", d, 0); end
    rst_n = 1'b1;
    @(negedge clk);

    // R8 readback masking
    wr(0, 8'hFF); rd(0, d); check("R8 sweep", d, 8'h7F);
    wr(1, 8'hFF); rd(1, d); check("R8 len", d, 8'hC0);
    wr(2, 8'hA5); rd(2, d); check("R8 env", d, 8'hA5);
    wr(3, 8'hFF); rd(3, d); check("R8 flo", d, 0);
    wr(4, 8'h47); rd(4, d); check("R8 fhi", d, 8'h40);
    check("R3 no trigger without bit7", int'(active), 0);

    // R1 duty sweep over all codes, N=1
    wr(0, 0); wr(2, 8'hF0);
    for (int dc = 0; dc < 4; dc++) begin
      int h;
      h = (dc == 0) ? 1 : (dc == 1) ? 2 : (dc == 2) ? 4 : 6;
      wr(1, dc << 6);
      trigger(2047, 1'b0);
      for (int k = 0; k < 16; k++) begin
        check("R1 duty", int'(sample), ((k % 8) < h) ? 15 : 0);
        tick(0);
      end
    end

    // R2 period length
    wr(1, 0);
    foreach (fl[i]) begin
      trigger(fl[i], 1'b0);
      check("R3 trigger start high", int'(sample), 15);
      count_until(1'b1, n); check("R2 first step", n, 2048 - fl[i]);
      count_until(1'b0, n); check("R2 seven steps", n, 7 * (2048 - fl[i]));
    end

    // R5 envelope
    wr(1, 8'hC0);
    wr(2, 8'hE9); trigger(2047, 1'b0);
    check("R5 init", int'(sample), 14);
    tick(2); check("R5 up", int'(sample), 15);
    tick(2); check("R5 sat 15", int'(sample), 15);
    wr(2, 8'h22); trigger(2047, 1'b0);
    begin
      int ev[5] = '{2, 1, 1, 0, 0};
      for (int k = 0; k < 5; k++) begin tick(2); check("R5 down P2", int'(sample), ev[k]); end
    end
    wr(2, 8'h58); trigger(2047, 1'b0);
    repeat (3) tick(2);
    check("R5 P0 frozen", int'(sample), 5);

    // R4 length
    wr(2, 8'hF0);
    wr(1, 8'hC0 | 60); trigger(2047, 1'b1);
    repeat (3) tick(1);
    check("R4 before expiry", int'(active), 1);
    tick(1);
    check("R4 expired", int'(active), 0);
    check("R10 silent", int'(sample), 0);
    repeat (3) tick(0);
    check("R10 silent with period ticks", int'(sample), 0);
    trigger(2047, 1'b1);
    check("R3 retrigger on", int'(active), 1);
    wr(1, 8'hC0); trigger(2047, 1'b1);
    repeat (63) tick(1);
    check("R4 L0 before 64", int'(active), 1);
    tick(1);
    check("R4 L0 at 64", int'(active), 0);
    wr(1, 8'hC0 | 60); trigger(2047, 1'b0);
    repeat (100) tick(1);
    check("R4 continuous", int'(active), 1);

    // R6 / R7 sweep
    wr(1, 0);
    wr(0, 8'h1B); trigger(2040, 1'b0);        // T1 sub S3: 2040 -> 1785
    tick(3);
    count_until(1'b1, n); check("R6 old period kept", n, 8);
    count_until(1'b0, n); check("R6 sub new period", n, 7 * 263);
    wr(0, 8'h14); trigger(1900, 1'b0);        // T1 add S4: 1900 -> 2018
    tick(3);
    count_until(1'b1, n); check("R6 add old period", n, 148);
    count_until(1'b0, n); check("R6 add new period", n, 7 * 30);
    wr(0, 8'h22); trigger(2000, 1'b0);        // T2 add S2: overflow
    tick(3); check("R6 interval 2 waits", int'(active), 1);
    tick(3); check("R7 overflow off", int'(active), 0);
    check("R7 sample 0", int'(sample), 0);
    wr(0, 8'h10); trigger(2000, 1'b0);        // S0
    repeat (3) tick(3);
    check("R6 S0 active", int'(active), 1);
    count_until(1'b1, n); check("R6 S0 unchanged", n, 48);
    wr(0, 8'h02); trigger(2000, 1'b0);        // T0
    repeat (3) tick(3);
    check("R6 T0 off", int'(active), 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule